// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a single 32-bit down-counter that a processor programs through four word-wide registers: a reload value, the live count, a control word and a one-bit status flag. The count moves down by one every P+1 cycles of the peripheral clock, where P is an 8-bit prescale field in the control word. When the count expires, the status flag is set. The counter then either stops at zero or refills from the reload value and keeps running.

Software starts the timer by setting the enable bit. It can rewrite the count at any time, which restarts the prescaler. It acknowledges an event by writing a one to the status flag. The interrupt line is a level output. It is high while the status flag is set and the interrupt-enable bit is on.

The bus side is a plain valid/write strobe with a word address and combinational read data. There is no wait state and no handshake.

Top module: `ptimer`

## Requirements
- R1: After reset, reads of the reload (offset 0x0), count (0x4), control (0x8) and status (0xC) registers all return zero and `irq` is low.
- R2: The reload and control registers read back the last value written. A read of any offset other than 0x0, 0x4, 0x8 or 0xC returns zero.
- R3: A write to the reload register also replaces the live count with the written value, exactly as a count write does.
- R4: With prescale field P (control bits 15:8) and the enable bit (control bit 0) set, the count drops by one every P+1 clock cycles. The first drop comes a full P+1 cycles after counting starts.
- R5: On expiry with auto-reload (control bit 1) clear, the status flag (status bit 0) is set and the count stays at zero.
- R6: On expiry with auto-reload set, the status flag is set and the count takes the reload value and keeps running.
- R7: A control write that keeps the enable bit set while the timer is already counting with a nonzero count leaves the countdown and prescaler undisturbed.
- R8: A control write that sets enable while the timer is stopped first copies the reload value into the count when auto-reload is set, then starts counting.
- R9: A zero count never counts or expires. A read of the count returns zero while the timer is disabled or the count is zero.
- R10: `irq` equals the status flag ANDed with the interrupt-enable bit (control bit 2). Writing a one to status bit 0 clears the flag, and `irq` falls at the same clock edge.
- R11: When a status clear and an expiry fall in the same cycle, the flag stays set.
- R12: A count write while the timer is running restarts the countdown from the new value with a full prescale period before the next drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every access is a whole 32-bit word and that a write strobe lasts exactly one cycle. Their "no interfering write" conditions also rely on the bus being idle whenever they claim a register is stable. The bench drives the strobe for a single cycle per access, always at the falling edge, and holds it low between accesses. The expiry-versus-clear case is timed so that the clear write lands on exactly the edge where the count expires. The other status clears are placed away from any expiry edge.

// File: rtl/ptimer.sv
module ptimer #(
  parameter int DW      = 32,
  parameter int ADDR_W  = 5,
  parameter int PSC_W   = 8,
  parameter int PSC_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12);

  logic [DW-1:0]    load_q, cnt_q, ctrl_q;
  logic [PSC_W-1:0] psc_q;
  logic             status_q;

  wire              en     = ctrl_q[0];
  wire              ar     = ctrl_q[1];
  wire              ie     = ctrl_q[2];
  wire [PSC_W-1:0]  presc  = ctrl_q[PSC_LSB +: PSC_W];
  wire              new_en = bus_wdata[0];
  wire              new_ar = bus_wdata[1];
  wire [PSC_W-1:0]  new_p  = bus_wdata[PSC_LSB +: PSC_W];

  wire wr      = bus_valid && bus_write;
  wire wr_load = wr && bus_addr == OFF_LOAD;
  wire wr_cnt  = wr && bus_addr == OFF_CNT;
  wire wr_ctl  = wr && bus_addr == OFF_CTL;
  wire wr_st   = wr && bus_addr == OFF_STAT;

  wire run     = en && cnt_q != '0;
  wire tick_ok = run && !wr_load && !wr_cnt && !(wr_ctl && !new_en);
  wire fire    = tick_ok && psc_q == '0 && cnt_q == DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      psc_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      if (wr_ctl)  ctrl_q <= bus_wdata;

      if (wr_load || wr_cnt) begin
        cnt_q <= bus_wdata;
        psc_q <= presc;
      end else if (wr_ctl && new_en && !run) begin
        if (new_ar) cnt_q <= load_q;
        psc_q <= new_p;
      end else if (tick_ok) begin
        if (psc_q != '0) begin
          psc_q <= psc_q - 1'b1;
        end else begin
          psc_q <= presc;
          if (cnt_q == DW'(1)) cnt_q <= ar ? load_q : '0;
          else                 cnt_q <= cnt_q - 1'b1;
        end
      end

      if (fire)                           status_q <= 1'b1;
      else if (wr_st && bus_wdata[0])     status_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        OFF_LOAD: bus_rdata = load_q;
        OFF_CNT:  bus_rdata = run ? cnt_q : '0;
        OFF_CTL:  bus_rdata = ctrl_q;
        OFF_STAT: bus_rdata = {{(DW-1){1'b0}}, status_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq = status_q && ie;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && psc_q != '0) |=> $stable(cnt_q));

  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ar) |=> (cnt_q == '0 && status_q));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ar) |=> (cnt_q == $past(load_q) && status_q));

  p_rerun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && new_en && run && psc_q != '0) |=> $stable(cnt_q));

  p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr_load && !wr_cnt && !(wr_ctl && new_ar)) |=> cnt_q == '0);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[0] && !fire) |=> !status_q && !irq);

  p_expiry_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status_q);
endmodule

// File: tb/ptimer_tb.sv
`timescale 1ns/1ps
module ptimer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ptimer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [4:0] A_LOAD = 5'h0, A_CNT = 5'h4, A_CTL = 5'h8, A_ST = 5'hC;

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1;
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq=%0b expected %0b", tag, irq, e);
    end
  endtask

  // monitor: pops the expected read value for every read strobe
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_valid && !bus_write) begin
        logic [31:0] e;
        string t;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL scoreboard: read with no expectation, rdata=%h expected none", bus_rdata);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_LOAD, 0, "R1 load"); rd(A_CNT, 0, "R1 count");
    rd(A_CTL, 0, "R1 ctrl");  rd(A_ST, 0, "R1 status");
    chk_irq(1'b0, "R1 irq");
    // R2 unmapped offsets
    rd(5'h10, 0, "R2 unmapped 0x10"); rd(5'h1C, 0, "R2 unmapped 0x1C");

    // R4 / R5: P=3, count 5, one-shot, irq enabled
    wr(A_LOAD, 5);
    rd(A_LOAD, 5, "R2 load readback");
    rd(A_CNT, 0, "R9 count reads zero while disabled");
    wr(A_CTL, 32'h305);                 // pos0
    idle(2);                            // pos2
    rd(A_CNT, 5, "R4 no drop before full period");  // j=3
    rd(A_CNT, 4, "R4 first drop");                   // j=5
    idle(12);                           // pos18
    rd(A_ST, 0, "R5 status before expiry");          // j=19
    rd(A_ST, 1, "R5 status after expiry");           // j=21
    rd(A_CNT, 0, "R5 count stays zero");
    chk_irq(1'b1, "R10 irq with enable");
    rd(A_CTL, 32'h305, "R2 ctrl readback");
    wr(A_CTL, 32'h001);
    chk_irq(1'b0, "R10 irq gated by enable bit");
    wr(A_CTL, 32'h005);
    chk_irq(1'b1, "R10 irq regated");
    wr(A_ST, 1);
    chk_irq(1'b0, "R10 irq drops with clear");
    rd(A_ST, 0, "R10 status cleared");

    // R6 auto-reload, P=0, load 3
    wr(A_CTL, 0);
    wr(A_LOAD, 3);
    wr(A_CTL, 32'h7);                  // pos0
    rd(A_CNT, 2, "R6 counting");       // j=1
    rd(A_CNT, 3, "R6 reloaded");       // j=3
    rd(A_ST, 1, "R6 status set");      // j=5

    // R7 re-enable while running, P=1, count 100
    wr(A_CTL, 0);
    wr(A_ST, 1);
    wr(A_LOAD, 100);
    wr(A_CTL, 32'h101);                // pos0
    idle(9);                           // pos9
    wr(A_CTL, 32'h101);                // applied E11, pos11
    rd(A_CNT, 94, "R7 countdown undisturbed");  // j=12

    // R8 enable from stopped copies reload value
    wr(A_CTL, 0);
    wr(A_CNT, 7);
    wr(A_CTL, 32'h3);
    rd(A_CNT, 99, "R8 load copied on start");
    // R3 load write also sets count while running
    wr(A_LOAD, 50);
    rd(A_CNT, 49, "R3 load write replaces count");

    // R12 count write restarts prescaler, P=3
    wr(A_CTL, 0);
    wr(A_CNT, 40);
    wr(A_CTL, 32'h301);                // pos0
    idle(1);                           // pos1
    wr(A_CNT, 20);                     // applied E3, pos3
    idle(2);                           // pos5
    rd(A_CNT, 20, "R12 full period after restart");  // j=6
    rd(A_CNT, 19, "R12 drop after restart");         // j=8

    // R9 zero count never starts
    wr(A_CTL, 0);
    wr(A_ST, 1);
    wr(A_LOAD, 0);
    wr(A_CTL, 32'h7);
    idle(10);
    rd(A_ST, 0, "R9 zero count never expires");
    rd(A_CNT, 0, "R9 zero count reads zero");
    chk_irq(1'b0, "R9 no irq on zero count");

    // R11 expiry beats clear in the same cycle, load 4, P=0
    wr(A_CTL, 0);
    wr(A_LOAD, 4);
    wr(A_CTL, 32'h7);                  // pos0, expiries at E4, E8, E12, E16
    idle(6);                           // pos6
    wr(A_ST, 1);                       // applied E8
    rd(A_ST, 1, "R11 expiry wins over clear");   // j=9
    idle(1);                           // pos11
    wr(A_ST, 1);                       // applied E13
    rd(A_ST, 0, "R10 clear away from expiry");   // j=14
    chk_irq(1'b0, "R10 irq low after clear");

    idle(4);
    if (exp_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard: pending=%0d expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule